// File: doc/BRIEF.md
# Watermark Interrupt Coalescing Controller

This block gathers eight device event sources into a sticky status register and turns them into a single CPU interrupt request. Each source raises its status bit with a one-cycle post pulse. Software clears bits with a write-one-to-clear vector. A mask selects which status bits may interrupt the CPU, and a global enable gates the final line.

Two watermark sources are edge-armed so that a FIFO sitting near a threshold cannot cause an interrupt storm. The rx-above-high-mark source only counts after an rx-empty arming event has been seen. The tx-below-low-mark source only counts after a tx-full arming event. Each arming flag is used up by the interrupt it lets through.

Most sources are coalesced: the first qualifying post starts a programmable down-counter, and the request is raised when that counter expires. Sources in the no-delay class raise the request at once, and they also cut short a countdown that is already running.

Top module: `wm_irq_coalesce`

## Requirements
- R1: After reset the status register reads zero, both arming flags are clear and `irq_o` is low.
- R2: The source index is the status bit position, LSB first:
  - 0 rx packet, 1 rx DMA done, 2 rx empty, 3 rx high;
  - 4 tx packet, 5 tx DMA done, 6 tx full, 7 tx low.
  
  A post pulse on bit b sets status bit b on the next clock edge.
- R3: When a post and a clear hit the same status bit in the same cycle, the bit stays set. A clear without a post on that bit zeroes it.
- R4: A post only schedules an interrupt through the bits of status AND `mask_i`. Posts whose bits are masked out never raise `irq_o`.
- R5: Rx-high (bit 3) takes part in a post's effective set only if the rx arming flag is set, and using it clears the flag.
  - An `rx_empty_evt_i` pulse sets the flag.
  - Without the flag, a post of bit 3 alone sets the status bit but raises no interrupt.
- R6: Tx-low (bit 7) behaves the same way with the tx arming flag, which is set by `tx_full_evt_i`.
- R7: If a post's effective set includes a no-delay bit (mask 0xCC: bits 2, 3, 6, 7), the request is visible on `irq_o` right after the clock edge that samples the post.
- R8: Otherwise, the first qualifying post loads the delay counter from `delay_i`.
  - The request appears `delay_i` clock edges later than it would for a no-delay post.
  - A delay of 0 behaves like a no-delay post.
  - Further delayed posts do not restart a running count.
- R9: A no-delay post arriving during a countdown cancels the count and raises the request at once.
- R10: `irq_o` is the internal request ANDed with `irq_en_i`, combinationally.
- R11: The request, and any running count, is dropped in the cycle where status AND mask becomes zero. A partial clear that leaves a masked-in bit keeps the request up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_i | input | 8 | Per-source post pulses |
| clr_i | input | 8 | Write-one-to-clear status bits |
| mask_i | input | 8 | Interrupt mask, 1 = enabled |
| rx_empty_evt_i | input | 1 | Arms the rx-high source |
| tx_full_evt_i | input | 1 | Arms the tx-low source |
| irq_en_i | input | 1 | Global interrupt enable |
| delay_i | input | DLY_W | Coalescing delay in cycles |
| status_o | output | 8 | Current status register |
| irq_o | output | 1 | CPU interrupt request |

## Verification
The assertions take `mask_i` and `delay_i` as ordinary synchronous inputs. They expect the effective set seen by the timer to always be a subset of the live masked status, and they place no limit on how posts, clears and arming pulses overlap. The random stimulus keeps post and clear vectors sparse so that countdowns actually run to expiry. It changes the mask, delay and enable only now and then so that the coalescing windows stay observable. It also overlaps posts with clears and with arming events on purpose, which exercises the priority and consumption rules.

// File: rtl/wmic_pkg.sv
package wmic_pkg;
  localparam int NSRC       = 8;
  localparam int RXHIGH_BIT = 3;
  localparam int TXLOW_BIT  = 7;
  localparam logic [NSRC-1:0] NODELAY_DEF = 8'hCC;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/wmic_status.sv
module wmic_status
  import wmic_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t post_i,
  input  src_vec_t clr_i,
  input  src_vec_t mask_i,
  output src_vec_t st_o,
  output src_vec_t live_o,
  output logic     upd_o
);
  src_vec_t st_q;
  src_vec_t st_d;

  // one next-state lane per source; post has priority over clear
  for (genvar b = 0; b < NSRC; b++) begin : g_lane
    always_comb begin
      if (post_i[b])     st_d[b] = 1'b1;
      else if (clr_i[b]) st_d[b] = 1'b0;
      else               st_d[b] = st_q[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st_o   = st_q;
  assign live_o = st_d & mask_i;
  assign upd_o  = |post_i;

  AST_POST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (post_i != '0) |=> ((st_q & $past(post_i)) == $past(post_i))); // R3
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~post_i) != '0) |=> ((st_q & $past(clr_i & ~post_i)) == '0)); // R3
endmodule

// File: rtl/wmic_arm.sv
module wmic_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  input  logic want_i,
  input  logic evt_i,
  output logic keep_o
);
  logic arm_q;
  logic arm_d;
  logic use_w;

  always_comb begin
    use_w  = upd_i & want_i & arm_q;
    keep_o = want_i & arm_q;
    arm_d  = evt_i | (arm_q & ~use_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end

  AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && keep_o && !evt_i) |=> !arm_q); // R5
  AST_ARM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> arm_q); // R6
endmodule

// File: rtl/wmic_timer.sv
module wmic_timer
  import wmic_pkg::*;
#(
  parameter int       DLY_W   = 8,
  parameter src_vec_t NODELAY = NODELAY_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  src_vec_t         live_i,
  input  src_vec_t         filt_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             ireq_o
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic             ireq_q, ireq_d;
  logic             run_q, run_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             fire_now;

  assign fire_now = (filt_i & NODELAY) != '0;

  always_comb begin
    ireq_d = ireq_q;
    run_d  = run_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (live_i == '0) begin
      ireq_d = 1'b0;
      run_d  = 1'b0;
    end else if (fire_now) begin
      ireq_d = 1'b1;
      run_d  = 1'b0;
    end else if ((filt_i != '0) && !ireq_q && !run_q) begin
      if (delay_i == '0) begin
        ireq_d = 1'b1;
      end else begin
        run_d  = 1'b1;
        cnt_d  = delay_i;
        cnt_en = 1'b1;
      end
    end else if (run_q) begin
      if (cnt_q == ONE) begin
        ireq_d = 1'b1;
        run_d  = 1'b0;
      end else begin
        cnt_d  = cnt_q - ONE;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ireq_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      ireq_q <= ireq_d;
      run_q  <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ireq_o = ireq_q;

  AST_FAST_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    fire_now |=> ireq_q); // R7
  AST_DROP_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i == '0) |=> !ireq_q); // R11
  AST_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == ONE && live_i != '0) |=> ireq_q); // R8
  AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && fire_now) |=> (!run_q && ireq_q)); // R9
endmodule

// File: rtl/wm_irq_coalesce.sv
module wm_irq_coalesce
  import wmic_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       post_i,
  input  logic [7:0]       clr_i,
  input  logic [7:0]       mask_i,
  input  logic             rx_empty_evt_i,
  input  logic             tx_full_evt_i,
  input  logic             irq_en_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic [7:0]       status_o,
  output logic             irq_o
);
  localparam int NWM = 2;
  localparam int WM_BIT [NWM] = '{RXHIGH_BIT, TXLOW_BIT};

  src_vec_t       st_w, live_w, filt_w;
  logic           upd_w;
  logic [NWM-1:0] keep_w;
  logic [NWM-1:0] evt_w;
  logic           ireq_w;

  assign evt_w = {tx_full_evt_i, rx_empty_evt_i};

  wmic_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .post_i (post_i),
    .clr_i  (clr_i),
    .mask_i (mask_i),
    .st_o   (st_w),
    .live_o (live_w),
    .upd_o  (upd_w)
  );

  for (genvar w = 0; w < NWM; w++) begin : g_wm
    wmic_arm u_arm (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_i  (upd_w),
      .want_i (live_w[WM_BIT[w]]),
      .evt_i  (evt_w[w]),
      .keep_o (keep_w[w])
    );
  end

  always_comb begin
    filt_w = upd_w ? live_w : '0;
    for (int w = 0; w < NWM; w++) begin
      filt_w[WM_BIT[w]] = upd_w & keep_w[w];
    end
  end

  wmic_timer #(.DLY_W(DLY_W), .NODELAY(NODELAY_DEF)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .live_i  (live_w),
    .filt_i  (filt_w),
    .delay_i (delay_i),
    .ireq_o  (ireq_w)
  );

  assign status_o = st_w;
  assign irq_o    = ireq_w & irq_en_i;

  AST_MASKED_NO_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_w & ~mask_i) == '0)); // R4
  AST_UNARMED_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (post_i == 8'h08 && !keep_w[0] && st_w == '0 && !ireq_w) |=> !ireq_w); // R5
endmodule

// File: tb/wm_irq_coalesce_bench.sv
module wm_irq_coalesce_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] post, clr, mask, dly;
  logic       rxe, txf, en;
  logic [7:0] status;
  logic       irq;
  int         checks = 0;
  int         errors = 0;

  logic [7:0] m_st, m_cnt;
  logic       m_rx, m_tx, m_ireq, m_run;

  always #10 clk = ~clk;

  wm_irq_coalesce u_wm_irq_coalesce (
    .clk(clk), .rst_n(rst_n), .post_i(post), .clr_i(clr), .mask_i(mask),
    .rx_empty_evt_i(rxe), .tx_full_evt_i(txf), .irq_en_i(en),
    .delay_i(dly), .status_o(status), .irq_o(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic [7:0] p, c, input logic re, te);
    logic [7:0] stn, live, f;
    logic ur, ut;
    stn = (m_st & ~c) | p;
    live = stn & mask;
    f = 8'h00; ur = 1'b0; ut = 1'b0;
    if (p != 8'h00) begin
      f = live;
      if (f[3]) begin if (m_rx) ur = 1'b1; else f[3] = 1'b0; end
      if (f[7]) begin if (m_tx) ut = 1'b1; else f[7] = 1'b0; end
    end
    if (live == 8'h00) begin
      m_ireq = 1'b0; m_run = 1'b0;
    end else if ((f & 8'hCC) != 8'h00) begin
      m_ireq = 1'b1; m_run = 1'b0;
    end else if (f != 8'h00 && !m_ireq && !m_run) begin
      if (dly == 8'h00) m_ireq = 1'b1;
      else begin m_run = 1'b1; m_cnt = dly; end
    end else if (m_run) begin
      if (m_cnt == 8'h01) begin m_ireq = 1'b1; m_run = 1'b0; end
      else m_cnt = m_cnt - 8'h01;
    end
    m_rx = re | (m_rx & ~ur);
    m_tx = te | (m_tx & ~ut);
    m_st = stn;
  endtask

  task automatic step(input logic [7:0] p, c, input logic re, te);
    post = p; clr = c; rxe = re; txf = te;
    model_step(p, c, re, te);
    @(negedge clk);
  endtask

  task automatic idle();
    step(8'h00, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic clear_all();
    step(8'h00, 8'hFF, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; post = 0; clr = 0; rxe = 0; txf = 0;
    mask = 8'hFF; en = 1'b1; dly = 8'd3;
    m_st = 0; m_cnt = 0; m_rx = 0; m_tx = 0; m_ireq = 0; m_run = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset irq", irq, 0);
    chk("R1 reset status", status, 8'h00);

    // R5: rx-high without arming flag
    step(8'h08, 0, 0, 0);
    chk("R5 unarmed rx-high irq", irq, 0);
    chk("R2 rx-high status bit 3", status, 8'h08);
    clear_all();
    step(0, 0, 1, 0);
    step(8'h08, 0, 0, 0);
    chk("R5 armed rx-high irq", irq, 1);
    clear_all();
    chk("R11 clear drops irq", irq, 0);
    step(8'h08, 0, 0, 0);
    chk("R5 flag consumed irq", irq, 0);
    clear_all();

    // R6: tx-low
    step(8'h80, 0, 0, 0);
    chk("R6 unarmed tx-low irq", irq, 0);
    clear_all();
    step(0, 0, 0, 1);
    step(8'h80, 0, 0, 0);
    chk("R6 armed tx-low irq", irq, 1);
    chk("R2 tx-low status bit 7", status, 8'h80);
    clear_all();
    step(8'h80, 0, 0, 0);
    chk("R6 flag consumed irq", irq, 0);
    clear_all();

    // R8: delay of 3
    step(8'h01, 0, 0, 0);
    chk("R8 delayed post irq at 0", irq, 0);
    idle();
    step(8'h10, 0, 0, 0);
    chk("R8 second post no restart at 2", irq, 0);
    idle();
    chk("R8 delayed post irq at 3", irq, 1);
    clear_all();

    // R9: no-delay cancels countdown
    step(8'h01, 0, 0, 0);
    idle();
    step(8'h04, 0, 0, 0);
    chk("R9 no-delay cuts count", irq, 1);
    chk("R7 rx-empty status", status, 8'h05);
    clear_all();

    // R8: zero delay
    dly = 8'd0;
    step(8'h10, 0, 0, 0);
    chk("R8 zero delay irq", irq, 1);
    clear_all();
    dly = 8'd3;

    // R4: masked-out source
    mask = 8'hFE;
    step(8'h01, 0, 0, 0);
    repeat (5) idle();
    chk("R4 masked source irq", irq, 0);
    chk("R4 masked source status", status, 8'h01);
    mask = 8'hFF;
    clear_all();

    // R3: post and clear on the same bit
    step(8'h04, 0, 0, 0);
    step(8'h04, 8'h04, 0, 0);
    chk("R3 post wins status", status, 8'h04);
    chk("R3 post wins irq", irq, 1);
    step(0, 8'h04, 0, 0);
    chk("R3 clear alone status", status, 8'h00);

    // R10: enable gating
    en = 1'b0;
    step(8'h40, 0, 0, 0);
    chk("R10 disabled irq", irq, 0);
    en = 1'b1;
    #1;
    chk("R10 enabled irq", irq, 1);
    @(negedge clk);
    clear_all();

    // R11: partial clear keeps request
    step(8'h05, 0, 0, 0);
    chk("R7 immediate irq", irq, 1);
    step(0, 8'h04, 0, 0);
    chk("R11 partial clear irq", irq, 1);
    step(0, 8'h01, 0, 0);
    chk("R11 last clear irq", irq, 0);

    // random phase checked against model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] p, c;
      p = ($urandom % 6 == 0) ? (8'($urandom) & 8'($urandom)) : 8'h00;
      c = ($urandom % 5 == 0) ? 8'($urandom) : 8'h00;
      if ($urandom % 200 == 0) mask = 8'($urandom) | 8'h11;
      if ($urandom % 150 == 0) en = ($urandom % 4 != 0);
      if ($urandom % 100 == 0) dly = 8'($urandom % 8);
      step(p, c, ($urandom % 12 == 0), ($urandom % 12 == 0));
      chk("R8 R9 random irq", irq, m_ireq & en);
      chk("R3 R5 R6 random status", status, m_st);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule